// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

Dynamic memory cells leak. A stored one disappears unless the cell's row is read and rewritten before the retention time runs out. A refresh restores a whole row at once. This block therefore asks for one refresh per row and spaces those requests evenly over the retention time. The spacing in clock cycles comes from three parameters: the clock rate, the retention time and the row count. With the default of 4096 rows, a 64 ms retention time and a 50 MHz clock, a request falls due every 781 cycles, which is roughly 15.6 µs. A refresh lasts about 100 ns, so the memory stays free for ordinary traffic more than 99% of the time.

The block raises a request and presents the address of the row to refresh. It holds both until the memory controller acknowledges. Each acknowledge moves the row pointer on by one. A controller busy with normal traffic may fall behind. In that case the block counts the refreshes still owed and keeps the request raised until the debt is paid. Once the debt reaches a set limit, it raises a warning flag.

Top module: `refresh_sched`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises, `refresh_req` and `refresh_overdue` are 0 and `refresh_row` is 0.
- R2: The interval is INTERVAL = CLK_KHZ*RETAIN_MS/ROW_COUNT cycles, rounded down. `refresh_req` first becomes 1 after exactly INTERVAL clock edges following reset release, and not before.
- R3: Interval expiries recur every INTERVAL cycles whether or not acknowledges arrive. With prompt acknowledges, successive rises of `refresh_req` are INTERVAL cycles apart.
- R4: `refresh_req` is 1 exactly while the owed count is nonzero. When one refresh is owed, an acknowledge lowers `refresh_req` on the next edge.
- R5: An acknowledge sampled while `refresh_req` is 1 is accepted. It advances `refresh_row` by one, visible after that edge.
- R6: `refresh_row` wraps from ROW_COUNT-1 to 0.
- R7: `refresh_ack` sampled while `refresh_req` is 0 is ignored. `refresh_row` holds and no debt is cleared.
- R8: Each interval expiry adds one to the owed count and each accepted acknowledge removes one. An expiry and an accepted acknowledge on the same edge leave the count unchanged, and the row still advances.
- R9: `refresh_overdue` is 1 exactly while the owed count is at least OVERDUE_LIMIT. It drops as soon as the count falls below that limit.
- R10: The owed count saturates at 2^PEND_W-1. Further expiries do not wrap it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_req | output | 1 | A refresh is owed |
| refresh_row | output | ROW_W (clog2 ROW_COUNT) | Row to refresh next |
| refresh_ack | input | 1 | Controller has taken the pending refresh |
| refresh_overdue | output | 1 | Owed count has reached OVERDUE_LIMIT |

## Verification
An interval expiry and an accepted acknowledge can land on the same clock edge. The first adds to the owed count and the second retires from it. The bench builds a debt of three refreshes, then holds the acknowledge high over the edge on which the next interval expires. It judges the result by three signs. The row advances, `refresh_overdue` stays 1 because the count is unchanged, and a single further acknowledge then clears the flag. Counting the acknowledges needed to drop `refresh_req` after a saturated debt confirms the same arithmetic from the outside.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  // Cycles between refresh requests: clock cycles in one retention period,
  // divided by the number of rows that must fit into it.
  function automatic int unsigned calc_interval(input int unsigned clk_khz,
                                                input int unsigned retain_ms,
                                                input int unsigned rows);
    return (clk_khz * retain_ms) / rows;
  endfunction

  // Increment with wrap at a last value that need not be a power of two.
  function automatic logic [31:0] wrap_inc(input logic [31:0] v,
                                           input logic [31:0] last);
    return (v == last) ? 32'd0 : v + 32'd1;
  endfunction

  // Owed-count update: add on expiry, retire on acceptance, saturate at top.
  function automatic logic [31:0] owed_next(input logic [31:0] cur,
                                            input logic        expire,
                                            input logic        take,
                                            input logic [31:0] top);
    logic [31:0] v;
    v = cur;
    if (expire && !take) v = (cur == top) ? top : cur + 32'd1;
    else if (take && !expire) v = cur - 32'd1;
    return v;
  endfunction

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int unsigned INTERVAL = 781
) (
  input  logic clk,
  input  logic rst_n,
  output logic expire
);
  localparam int unsigned CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (expire) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R3
  expire_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);

endmodule

// File: rtl/refresh_row_counter.sv
module refresh_row_counter #(
  parameter int unsigned ROW_COUNT = 4096,
  localparam int unsigned ROW_W = $clog2(ROW_COUNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [ROW_W-1:0] row
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROW_COUNT - 1);

  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       row_q <= '0;
    else if (advance) row_q <= ROW_W'(refresh_pkg::wrap_inc(32'(row_q), 32'(LAST_ROW)));
  end

  assign row = row_q;

  // R6
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && row_q == LAST_ROW) |=> row_q == '0);

  // R7
  row_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(row_q));

endmodule

// File: rtl/refresh_owed_counter.sv
module refresh_owed_counter #(
  parameter int unsigned PEND_W = 4,
  localparam int unsigned TOP = (1 << PEND_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic              take,
  output logic [PEND_W-1:0] owed
);
  localparam logic [PEND_W-1:0] TOP_V = PEND_W'(TOP);

  logic [PEND_W-1:0] owed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) owed_q <= '0;
    else        owed_q <= PEND_W'(refresh_pkg::owed_next(32'(owed_q), expire, take, 32'(TOP_V)));
  end

  assign owed = owed_q;

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_q == TOP_V && expire && !take) |=> owed_q == TOP_V);

  // R8
  retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !expire) |=> owed_q == $past(owed_q) - PEND_W'(1));

  // R8
  balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && expire) |=> $stable(owed_q));

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int unsigned CLK_KHZ       = 50000,
  parameter int unsigned RETAIN_MS     = 64,
  parameter int unsigned ROW_COUNT     = 4096,
  parameter int unsigned PEND_W        = 4,
  parameter int unsigned OVERDUE_LIMIT = 8,
  localparam int unsigned ROW_W = $clog2(ROW_COUNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             refresh_req,
  output logic [ROW_W-1:0] refresh_row,
  input  logic             refresh_ack,
  output logic             refresh_overdue
);
  localparam int unsigned INTERVAL = refresh_pkg::calc_interval(CLK_KHZ, RETAIN_MS, ROW_COUNT);
  localparam logic [PEND_W-1:0] LIMIT_V = PEND_W'(OVERDUE_LIMIT);

  // Named internal events, brought out for the checks below.
  logic              tick;
  logic              accept;
  logic [PEND_W-1:0] owed;

  refresh_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .expire(tick));

  refresh_owed_counter #(.PEND_W(PEND_W)) u_owed (
    .clk(clk), .rst_n(rst_n), .expire(tick), .take(accept), .owed(owed));

  refresh_row_counter #(.ROW_COUNT(ROW_COUNT)) u_row (
    .clk(clk), .rst_n(rst_n), .advance(accept), .row(refresh_row));

  assign refresh_req     = (owed != '0);
  assign accept          = refresh_ack && refresh_req;
  assign refresh_overdue = (owed >= LIMIT_V);

  initial begin
    if (INTERVAL < 2) $error("refresh interval below two cycles");
    if (OVERDUE_LIMIT < 1 || OVERDUE_LIMIT > (1 << PEND_W) - 1)
      $error("overdue limit outside owed-count range");
  end

  // R2
  req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_req) |-> $past(tick));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !refresh_ack) |=> refresh_req);

  // R5
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> refresh_row != $past(refresh_row));

  // R9
  overdue_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_overdue) |-> $past(tick));

endmodule

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;
  localparam int unsigned ROWS   = 16;
  localparam int unsigned IVL    = 10;   // 160 kHz * 1 ms / 16 rows
  localparam int unsigned LIMIT  = 3;
  localparam int unsigned OWEMAX = 7;    // PEND_W = 3

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ack = 1'b0;
  logic       req;
  logic       ovd;
  logic [3:0] row;

  int unsigned vectors = 0;
  int unsigned misses  = 0;

  always #10 clk = ~clk;

  refresh_sched #(.CLK_KHZ(160), .RETAIN_MS(1), .ROW_COUNT(ROWS),
                  .PEND_W(3), .OVERDUE_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .refresh_req(req), .refresh_row(row),
    .refresh_ack(ack), .refresh_overdue(ovd));

  typedef struct packed {
    logic [7:0] n;    // cycles to run
    logic       a;    // ack level held for them
    logic [3:0] row;  // expected afterwards
    logic       req;
    logic       ov;
    logic [3:0] rid;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{8'd9,  1'b0, 4'd0, 1'b0, 1'b0, 4'd2},  // R2 edge 9, nothing yet
    '{8'd1,  1'b0, 4'd0, 1'b1, 1'b0, 4'd2},  // R2 edge 10, first request
    '{8'd1,  1'b1, 4'd1, 1'b0, 1'b0, 4'd5},  // R5 R4 accepted
    '{8'd3,  1'b1, 4'd1, 1'b0, 1'b0, 4'd7},  // R7 ack while idle ignored
    '{8'd5,  1'b0, 4'd1, 1'b0, 1'b0, 4'd7},  // R7 no debt was cleared
    '{8'd1,  1'b0, 4'd1, 1'b1, 1'b0, 4'd3},  // R3 edge 20
    '{8'd10, 1'b0, 4'd1, 1'b1, 1'b0, 4'd8},  // R8 owed 2
    '{8'd10, 1'b0, 4'd1, 1'b1, 1'b1, 4'd9},  // R9 owed 3 hits limit
    '{8'd9,  1'b0, 4'd1, 1'b1, 1'b1, 4'd9},  // R9 edge 49
    '{8'd1,  1'b1, 4'd2, 1'b1, 1'b1, 4'd8},  // R8 expiry and ack together
    '{8'd1,  1'b1, 4'd3, 1'b1, 1'b0, 4'd9},  // R9 owed 2 clears flag
    '{8'd2,  1'b1, 4'd5, 1'b0, 1'b0, 4'd4},  // R4 debt paid
    '{8'd1,  1'b0, 4'd5, 1'b0, 1'b0, 4'd4}   // R4 stays low
  };

  task automatic cyc(input logic a);
    ack = a;
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic do_reset();
    ack = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 20000);
    misses++;
    $display("FAIL watchdog: got hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    // R1 reset state
    ack = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R1 req", 32'(req), 0);
    check("R1 row", 32'(row), 0);
    check("R1 overdue", 32'(ovd), 0);
    do_reset();
    cyc(1'b0);
    check("R1 req after first edge", 32'(req), 0);
    check("R1 row after first edge", 32'(row), 0);

    // Restart the interval so the table's edge counts start clean.
    do_reset();
    foreach (VECS[i]) begin
      for (int k = 0; k < int'(VECS[i].n); k++) cyc(VECS[i].a);
      check($sformatf("R%0d row v%0d", VECS[i].rid, i), 32'(row), 32'(VECS[i].row));
      check($sformatf("R%0d req v%0d", VECS[i].rid, i), 32'(req), 32'(VECS[i].req));
      check($sformatf("R%0d ovd v%0d", VECS[i].rid, i), 32'(ovd), 32'(VECS[i].ov));
    end

    // R3 spacing and R6 wrap: row 5 forward through 15 back to 0.
    for (int i = 0; i < 11; i++) begin
      int waits;
      waits = 0;
      while (!req && waits < 40) begin
        cyc(1'b0);
        waits++;
      end
      if (i > 0) check("R3 spacing", 32'(waits + 1), IVL);
      cyc(1'b1);
      check("R6 R5 row step", 32'(row), (6 + i) % ROWS);
      check("R4 req drops", 32'(req), 0);
    end
    check("R6 wrapped to zero", 32'(row), 0);

    // R10 saturation: ten expiries, only seven owed.
    do_reset();
    repeat (100) cyc(1'b0);
    check("R9 overdue at saturation", 32'(ovd), 1);
    for (int i = 0; i < int'(OWEMAX); i++) begin
      check("R10 req before debt paid", 32'(req), 1);
      cyc(1'b1);
      if (i == 3) check("R9 owed 3 still overdue", 32'(ovd), 1);
      if (i == 4) check("R9 owed 2 clear", 32'(ovd), 0);
    end
    ack = 1'b0;
    check("R10 seven acks pay saturated debt", 32'(req), 0);
    check("R10 row after seven", 32'(row), 7);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule